// File: doc/BRIEF.md
# Bridge command register file

This block is the host-facing control and status register file of a two-port bridge. One host reads and writes 32-bit words through a simple register port with one cycle of read latency. It writes an argument and the address, size and argument words, then a command word. The block decodes the command and checks its argument. It then hands the configuration to the downstream translation logic as a strobe that is held until that logic accepts it. Completion or failure is reported in a status word.

One instance serves each side of the bridge. A third command marks the local host application as bound. The local bound flag is driven out to the other side, and the other side's flag comes back in. A one-cycle link-up pulse is raised once, when both flags are set. The block also holds 32 message-data words, one per doorbell interrupt. The host can read and write these words, and the translation logic reads them through a separate indexed port.

Top module: `xbr_cmd_regfile`

## Requirements
- R1: After reset the status word reads 0 (idle), the command word reads 0, both configuration strobes are low, and the bound flag and the link-up pulse are low.
- R2: Word map: 0 command, 1 argument, 2 status, 3 topology, 4 address low, 5 address high, 6 size, 7 window count, 8 window-1 offset, 9 scratchpad offset, 10 scratchpad count, 11 doorbell entry size, and 12 to 43 the doorbell data words. The argument, address and size words read back what was written. Words 7 to 11 report parameter values, and writes to them have no effect. Topology reads 1 on the primary side and 2 on the secondary side. An unmapped word reads 0.
- R3: Command 1 configures doorbells. It raises the doorbell strobe with count = argument[15:0] and MSI-X select = argument[16], where 1 means MSI-X and 0 means MSI.
- R4: Command 2 configures a memory window. It raises the window strobe with index = argument, a 64-bit target = {address high, address low} and length = size.
- R5: Status encoding is 0 idle, 1 busy, 2 success, 3 error. A nonzero command write sets busy. A strobe stays high with stable fields until cfg_ready is sampled high. One cycle after that acceptance, status reads 2 and the command word reads 0.
- R6: An unknown command code (anything other than 1, 2 or 3), a doorbell count above 32, or a window index of 0 or above the window count sets status 3, clears the command word and raises no strobe.
- R7: Writing the same command code again after completion runs the command again and produces a second strobe.
- R8: Command 3 sets the local bound flag and completes with status 2. link_up pulses for exactly one cycle, once after reset, after both the local flag and peer_bound are set. The pulse is not raised while only one of them is set.
- R9: The 32 doorbell data words are readable and writable by the host. db_rd_data returns the word selected by db_rd_idx one cycle later.
- R10: A command write while a command is in progress has no effect. A write of 0 to the command word has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host register write enable |
| host_rd | input | 1 | Host register read enable |
| host_addr | input | 6 | Host word index |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, valid one cycle after host_rd |
| cfg_ready | input | 1 | Downstream accepts the pending strobe |
| db_cfg_valid | output | 1 | Doorbell configuration strobe |
| db_cfg_count | output | 16 | Number of doorbells to set up |
| db_cfg_msix | output | 1 | 1 = MSI-X, 0 = MSI |
| mw_cfg_valid | output | 1 | Memory-window configuration strobe |
| mw_cfg_index | output | 3 | Window index |
| mw_cfg_addr | output | 64 | Window target address |
| mw_cfg_size | output | 32 | Window length |
| db_rd_idx | input | 5 | Doorbell data word select for the translation logic |
| db_rd_data | output | 32 | Selected doorbell data word, one cycle later |
| peer_bound | input | 1 | Bound flag of the other side |
| local_bound | output | 1 | Bound flag of this side |
| link_up | output | 1 | One-cycle link-up pulse |

## Verification
The hardest case to reach from the ports is a second command write that lands while the first is still waiting for acceptance. The stimulus holds cfg_ready low and writes a new code during that wait. It then reads the command word to confirm the pending code is still there, and counts the strobes once cfg_ready is released. A second hard case is the link rendezvous. The peer flag is held low well after the local bind, so an early pulse would be seen, and the bind is then repeated after the pulse to show that it fires only once. Random commands, with random arguments on both sides of every range limit and random acceptance stalls, are checked against bench functions that compute the expected status and strobe fields.

// File: rtl/xbr_cmd_pkg.sv
package xbr_cmd_pkg;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_BUSY = 2'd1, ST_OK = 2'd2, ST_ERR = 2'd3} stat_e;
  typedef enum logic [1:0] {ACT_ERR, ACT_DB, ACT_MW, ACT_LINK} act_e;
  typedef enum logic [1:0] {PH_IDLE, PH_DEC, PH_WAIT, PH_DONE} phase_e;

  localparam logic [31:0] OP_DB   = 32'd1;
  localparam logic [31:0] OP_MW   = 32'd2;
  localparam logic [31:0] OP_LINK = 32'd3;

  localparam int W_CMD     = 0;
  localparam int W_ARG     = 1;
  localparam int W_STAT    = 2;
  localparam int W_TOPO    = 3;
  localparam int W_ALO     = 4;
  localparam int W_AHI     = 5;
  localparam int W_SIZE    = 6;
  localparam int W_MWCNT   = 7;
  localparam int W_MW1OFS  = 8;
  localparam int W_SPOFS   = 9;
  localparam int W_SPCNT   = 10;
  localparam int W_DBESZ   = 11;
  localparam int W_DB_BASE = 12;
endpackage

// File: rtl/xbr_cmd_decode.sv
module xbr_cmd_decode
  import xbr_cmd_pkg::*;
#(
  parameter int MAX_DB = 32,
  parameter int NUM_MW = 4
)(
  input  logic [31:0] cmd_i,
  input  logic [31:0] arg_i,
  output act_e        act_o
);
  logic db_ok, mw_ok;

  assign db_ok = 32'(arg_i[15:0]) <= 32'(MAX_DB);
  assign mw_ok = (arg_i >= 32'd1) && (arg_i <= 32'(NUM_MW));

  always_comb begin
    case (cmd_i)
      OP_DB:   act_o = db_ok ? ACT_DB : ACT_ERR;
      OP_MW:   act_o = mw_ok ? ACT_MW : ACT_ERR;
      OP_LINK: act_o = ACT_LINK;
      default: act_o = ACT_ERR;
    endcase
  end
endmodule

// File: rtl/xbr_db_ram.sv
module xbr_db_ram #(
  parameter int DEPTH = 32,
  parameter int AW    = $clog2(DEPTH)
)(
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [31:0]   wdata_i,
  input  logic          ra_en_i,
  input  logic [AW-1:0] ra_addr_i,
  output logic [31:0]   ra_data_o,
  input  logic [AW-1:0] rb_addr_i,
  output logic [31:0]   rb_data_o
);
  logic [31:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    if (ra_en_i) ra_data_o <= mem[ra_addr_i];
    rb_data_o <= mem[rb_addr_i];
  end
endmodule

// File: rtl/xbr_link_sync.sv
module xbr_link_sync (
  input  logic clk,
  input  logic rst,
  input  logic set_bound_i,
  input  logic peer_bound_i,
  output logic bound_o,
  output logic link_up_o
);
  logic fired_q;
  logic fire;

  assign fire = bound_o && peer_bound_i && !fired_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bound_o   <= 1'b0;
      fired_q   <= 1'b0;
      link_up_o <= 1'b0;
    end else begin
      if (set_bound_i) bound_o <= 1'b1;
      fired_q   <= fired_q | fire;
      link_up_o <= fire;
    end
  end

  // R8
  link_single_chk: assert property (@(posedge clk) disable iff (rst)
    link_up_o |=> !link_up_o);
  // R8
  link_cause_chk: assert property (@(posedge clk) disable iff (rst)
    link_up_o |-> (bound_o && $past(peer_bound_i)));
endmodule

// File: rtl/xbr_cmd_regfile.sv
module xbr_cmd_regfile
  import xbr_cmd_pkg::*;
#(
  parameter int          DB_WORDS      = 32,
  parameter int          NUM_MW        = 4,
  parameter bit          IS_PRIMARY    = 1'b1,
  parameter logic [31:0] MW1_OFFSET    = 32'h0000_0100,
  parameter logic [31:0] SPAD_OFFSET   = 32'h0000_00B0,
  parameter logic [31:0] SPAD_COUNT    = 32'd16,
  parameter logic [31:0] DB_ENTRY_SIZE = 32'd4,
  localparam int ADDR_W = $clog2(W_DB_BASE + DB_WORDS),
  localparam int DB_AW  = $clog2(DB_WORDS),
  localparam int IDX_W  = $clog2(NUM_MW + 1)
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  input  logic              cfg_ready,
  output logic              db_cfg_valid,
  output logic [15:0]       db_cfg_count,
  output logic              db_cfg_msix,
  output logic              mw_cfg_valid,
  output logic [IDX_W-1:0]  mw_cfg_index,
  output logic [63:0]       mw_cfg_addr,
  output logic [31:0]       mw_cfg_size,
  input  logic [DB_AW-1:0]  db_rd_idx,
  output logic [31:0]       db_rd_data,
  input  logic              peer_bound,
  output logic              local_bound,
  output logic              link_up
);
  localparam logic [31:0] TOPO_VAL = IS_PRIMARY ? 32'd1 : 32'd2;

  logic [31:0] cmd_q, arg_q, alo_q, ahi_q, size_q;
  stat_e       status_q;
  phase_e      ph_q;
  act_e        act;
  logic [31:0] a32;
  logic        ram_hit;
  logic [DB_AW-1:0] ram_idx;
  logic [31:0] ram_rdata, reg_rd_q;
  logic        sel_ram_q;
  logic        set_bound;

  assign a32     = 32'(host_addr);
  assign ram_hit = (a32 >= 32'(W_DB_BASE)) && (a32 < 32'(W_DB_BASE + DB_WORDS));
  assign ram_idx = DB_AW'(a32 - 32'(W_DB_BASE));

  xbr_cmd_decode #(.MAX_DB(DB_WORDS), .NUM_MW(NUM_MW)) u_dec (
    .cmd_i(cmd_q), .arg_i(arg_q), .act_o(act)
  );

  xbr_db_ram #(.DEPTH(DB_WORDS), .AW(DB_AW)) u_ram (
    .clk(clk),
    .we_i(host_wr && ram_hit), .waddr_i(ram_idx), .wdata_i(host_wdata),
    .ra_en_i(host_rd && ram_hit), .ra_addr_i(ram_idx), .ra_data_o(ram_rdata),
    .rb_addr_i(db_rd_idx), .rb_data_o(db_rd_data)
  );

  assign set_bound = (ph_q == PH_DEC) && (act == ACT_LINK);

  xbr_link_sync u_link (
    .clk(clk), .rst(rst), .set_bound_i(set_bound), .peer_bound_i(peer_bound),
    .bound_o(local_bound), .link_up_o(link_up)
  );

  // Command sequencing and writable words
  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q        <= '0;
      arg_q        <= '0;
      alo_q        <= '0;
      ahi_q        <= '0;
      size_q       <= '0;
      status_q     <= ST_IDLE;
      ph_q         <= PH_IDLE;
      db_cfg_valid <= 1'b0;
      db_cfg_count <= '0;
      db_cfg_msix  <= 1'b0;
      mw_cfg_valid <= 1'b0;
      mw_cfg_index <= '0;
      mw_cfg_addr  <= '0;
      mw_cfg_size  <= '0;
    end else begin
      if (host_wr) begin
        case (a32)
          W_ARG:  arg_q  <= host_wdata;
          W_ALO:  alo_q  <= host_wdata;
          W_AHI:  ahi_q  <= host_wdata;
          W_SIZE: size_q <= host_wdata;
          W_CMD: if (ph_q == PH_IDLE && host_wdata != '0) begin
            cmd_q    <= host_wdata;
            status_q <= ST_BUSY;
            ph_q     <= PH_DEC;
          end
          default: ;
        endcase
      end
      case (ph_q)
        PH_DEC: begin
          case (act)
            ACT_DB: begin
              db_cfg_valid <= 1'b1;
              db_cfg_count <= arg_q[15:0];
              db_cfg_msix  <= arg_q[16];
              ph_q         <= PH_WAIT;
            end
            ACT_MW: begin
              mw_cfg_valid <= 1'b1;
              mw_cfg_index <= IDX_W'(arg_q);
              mw_cfg_addr  <= {ahi_q, alo_q};
              mw_cfg_size  <= size_q;
              ph_q         <= PH_WAIT;
            end
            ACT_LINK: begin
              status_q <= ST_OK;
              cmd_q    <= '0;
              ph_q     <= PH_IDLE;
            end
            default: begin
              status_q <= ST_ERR;
              cmd_q    <= '0;
              ph_q     <= PH_IDLE;
            end
          endcase
        end
        PH_WAIT: if (cfg_ready) begin
          db_cfg_valid <= 1'b0;
          mw_cfg_valid <= 1'b0;
          ph_q         <= PH_DONE;
        end
        PH_DONE: begin
          status_q <= ST_OK;
          cmd_q    <= '0;
          ph_q     <= PH_IDLE;
        end
        default: ;
      endcase
    end
  end

  // Registered host read
  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rd_q  <= '0;
      sel_ram_q <= 1'b0;
    end else if (host_rd) begin
      sel_ram_q <= ram_hit;
      case (a32)
        W_CMD:    reg_rd_q <= cmd_q;
        W_ARG:    reg_rd_q <= arg_q;
        W_STAT:   reg_rd_q <= {30'd0, status_q};
        W_TOPO:   reg_rd_q <= TOPO_VAL;
        W_ALO:    reg_rd_q <= alo_q;
        W_AHI:    reg_rd_q <= ahi_q;
        W_SIZE:   reg_rd_q <= size_q;
        W_MWCNT:  reg_rd_q <= 32'(NUM_MW);
        W_MW1OFS: reg_rd_q <= MW1_OFFSET;
        W_SPOFS:  reg_rd_q <= SPAD_OFFSET;
        W_SPCNT:  reg_rd_q <= SPAD_COUNT;
        W_DBESZ:  reg_rd_q <= DB_ENTRY_SIZE;
        default:  reg_rd_q <= '0;
      endcase
    end
  end

  assign host_rdata = sel_ram_q ? ram_rdata : reg_rd_q;

  // R5
  strobe_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (db_cfg_valid || mw_cfg_valid) |-> (status_q == ST_BUSY));
  // R5
  db_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (db_cfg_valid && !cfg_ready) |=> (db_cfg_valid && $stable(db_cfg_count) && $stable(db_cfg_msix)));
  // R5
  mw_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mw_cfg_valid && !cfg_ready) |=> (mw_cfg_valid && $stable(mw_cfg_addr) && $stable(mw_cfg_size)));
  // R5
  accept_ok_chk: assert property (@(posedge clk) disable iff (rst)
    ((db_cfg_valid || mw_cfg_valid) && cfg_ready) |=> ##1 (status_q == ST_OK && cmd_q == '0));
  // R6
  err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (status_q == ST_ERR) |-> (!db_cfg_valid && !mw_cfg_valid && cmd_q == '0));
  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(db_cfg_valid && mw_cfg_valid));
endmodule

// File: tb/xbr_cmd_regfile_bench.sv
`timescale 1ns/1ps
module xbr_cmd_regfile_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [5:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        cfg_ready = 1'b0;
  logic        db_cfg_valid, db_cfg_msix, mw_cfg_valid;
  logic [15:0] db_cfg_count;
  logic [2:0]  mw_cfg_index;
  logic [63:0] mw_cfg_addr;
  logic [31:0] mw_cfg_size;
  logic [4:0]  db_rd_idx = '0;
  logic [31:0] db_rd_data;
  logic        peer_bound = 1'b0;
  logic        local_bound, link_up;

  int total = 0, fails = 0;
  bit done = 1'b0;
  logic [31:0] dbmem [32];
  logic [31:0] rv;
  int n_db, n_mw;
  logic [15:0] r_cnt; logic r_msix; logic [2:0] r_idx; logic [63:0] r_addr; logic [31:0] r_size;

  always #2 clk = ~clk;

  xbr_cmd_regfile u_xbr_cmd_regfile (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .cfg_ready(cfg_ready),
    .db_cfg_valid(db_cfg_valid), .db_cfg_count(db_cfg_count), .db_cfg_msix(db_cfg_msix),
    .mw_cfg_valid(mw_cfg_valid), .mw_cfg_index(mw_cfg_index), .mw_cfg_addr(mw_cfg_addr),
    .mw_cfg_size(mw_cfg_size), .db_rd_idx(db_rd_idx), .db_rd_data(db_rd_data),
    .peer_bound(peer_bound), .local_bound(local_bound), .link_up(link_up)
  );

  task automatic tick; @(posedge clk); #1; endtask

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    host_wr = 1'b1; host_addr = 6'(a); host_wdata = d;
    tick;
    host_wr = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    host_rd = 1'b1; host_addr = 6'(a);
    tick;
    host_rd = 1'b0;
    d = host_rdata;
  endtask

  function automatic bit exp_ok(logic [31:0] code, logic [31:0] arg);
    case (code)
      32'd1: return 32'(arg[15:0]) <= 32'd32;
      32'd2: return (arg >= 32'd1) && (arg <= 32'd4);
      32'd3: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // Watch strobes for a number of cycles; ready random when stall is set
  task automatic watch(int cycles, bit stall);
    for (int i = 0; i < cycles; i++) begin
      cfg_ready = stall ? ((i >= 6) || ($urandom % 3 == 0)) : 1'b1;
      if (db_cfg_valid && cfg_ready) begin n_db++; r_cnt = db_cfg_count; r_msix = db_cfg_msix; end
      if (mw_cfg_valid && cfg_ready) begin n_mw++; r_idx = mw_cfg_index; r_addr = mw_cfg_addr; r_size = mw_cfg_size; end
      tick;
    end
    cfg_ready = 1'b0;
  endtask

  task automatic run_cmd(logic [31:0] code, logic [31:0] arg, logic [31:0] alo,
                         logic [31:0] ahi, logic [31:0] sz, bit stall);
    bit ok;
    logic [31:0] st;
    ok = exp_ok(code, arg);
    n_db = 0; n_mw = 0;
    wr(1, arg); wr(4, alo); wr(5, ahi); wr(6, sz);
    cfg_ready = 1'b0;
    wr(0, code);
    rd(2, st);
    chk(st == 32'd1, "R5 busy after command write", st, 1);
    watch(25, stall);
    chk(n_db == ((ok && code == 1) ? 1 : 0), "R3/R6 doorbell strobe count", n_db, (ok && code == 1));
    chk(n_mw == ((ok && code == 2) ? 1 : 0), "R4/R6 window strobe count", n_mw, (ok && code == 2));
    if (ok && code == 1) begin
      chk(r_cnt == arg[15:0], "R3 doorbell count", r_cnt, arg[15:0]);
      chk(r_msix == arg[16], "R3 msix select", r_msix, arg[16]);
    end
    if (ok && code == 2) begin
      chk(r_idx == 3'(arg), "R4 window index", r_idx, arg);
      chk(r_addr == {ahi, alo}, "R4 window address", r_addr, {ahi, alo});
      chk(r_size == sz, "R4 window size", r_size, sz);
    end
    rd(2, st);
    chk(st == (ok ? 32'd2 : 32'd3), "R5/R6 final status", st, ok ? 2 : 3);
    rd(0, st);
    chk(st == 32'd0, "R5 command self-clear", st, 0);
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (5) tick;
    rst = 1'b0;
    tick;

    // R1 reset state
    chk(!db_cfg_valid && !mw_cfg_valid, "R1 strobes low", {db_cfg_valid, mw_cfg_valid}, 0);
    chk(!local_bound && !link_up, "R1 link state", {local_bound, link_up}, 0);
    rd(2, rv); chk(rv == 0, "R1 status idle", rv, 0);
    rd(0, rv); chk(rv == 0, "R1 command zero", rv, 0);

    // R2 map
    rd(3, rv);  chk(rv == 1, "R2 topology primary", rv, 1);
    rd(7, rv);  chk(rv == 4, "R2 window count", rv, 4);
    rd(8, rv);  chk(rv == 32'h100, "R2 window-1 offset", rv, 32'h100);
    rd(9, rv);  chk(rv == 32'hB0, "R2 scratchpad offset", rv, 32'hB0);
    rd(10, rv); chk(rv == 16, "R2 scratchpad count", rv, 16);
    rd(11, rv); chk(rv == 4, "R2 entry size", rv, 4);
    wr(7, 32'hDEAD_BEEF); rd(7, rv); chk(rv == 4, "R2 read-only ignores write", rv, 4);
    wr(3, 32'h55); rd(3, rv); chk(rv == 1, "R2 topology ignores write", rv, 1);
    wr(6, 32'hA5A5_0001); rd(6, rv); chk(rv == 32'hA5A5_0001, "R2 size readback", rv, 32'hA5A5_0001);
    wr(5, 32'h0000_00FF); rd(5, rv); chk(rv == 32'hFF, "R2 address high readback", rv, 32'hFF);
    rd(44, rv); chk(rv == 0, "R2 unmapped word", rv, 0);

    // R9 doorbell data words
    for (int i = 0; i < 32; i++) begin
      dbmem[i] = $urandom;
      wr(12 + i, dbmem[i]);
    end
    for (int i = 0; i < 32; i += 5) begin
      rd(12 + i, rv); chk(rv == dbmem[i], "R9 host readback", rv, dbmem[i]);
    end
    rd(43, rv); chk(rv == dbmem[31], "R9 last word", rv, dbmem[31]);
    for (int i = 0; i < 32; i += 3) begin
      db_rd_idx = 5'(i); tick;
      chk(db_rd_data == dbmem[i], "R9 downstream read", db_rd_data, dbmem[i]);
    end

    // Directed corners
    run_cmd(1, 32'h0001_0020, 0, 0, 0, 1'b0);          // R3 count 32, MSI-X
    run_cmd(1, 32'h0000_0021, 0, 0, 0, 1'b0);          // R6 count 33
    run_cmd(1, 32'h0000_0007, 0, 0, 0, 1'b1);          // R3 MSI
    run_cmd(2, 0, 32'h1000, 32'h2, 32'h400, 1'b0);     // R6 index 0
    run_cmd(2, 5, 32'h1000, 32'h2, 32'h400, 1'b0);     // R6 index 5
    run_cmd(2, 4, 32'hCAFE_0000, 32'h1234_5678, 32'h8000, 1'b1); // R4 top index
    run_cmd(7, 0, 0, 0, 0, 1'b0);                      // R6 unknown code
    // R7 retrigger same code
    run_cmd(2, 1, 32'h10, 32'h20, 32'h30, 1'b0);
    run_cmd(2, 1, 32'h10, 32'h20, 32'h30, 1'b0);

    // R10 write of 0 has no effect
    wr(0, 0);
    n_db = 0; n_mw = 0; watch(5, 1'b0);
    rd(2, rv); chk(rv == 2, "R10 zero write keeps status", rv, 2);
    chk(n_db + n_mw == 0, "R10 zero write no strobe", n_db + n_mw, 0);

    // R10 command write while busy is ignored
    wr(1, 3); wr(0, 2);
    tick; tick;
    wr(1, 32'd5); wr(0, 1);
    rd(0, rv); chk(rv == 2, "R10 pending command kept", rv, 2);
    n_db = 0; n_mw = 0; watch(10, 1'b0);
    chk(n_mw == 1 && n_db == 0, "R10 single strobe", {n_mw, n_db}, 64'h1_0000_0000);
    chk(r_idx == 3, "R10 original index used", r_idx, 3);

    // Random commands
    for (int k = 0; k < 40; k++) begin
      int sel;
      logic [31:0] code, arg;
      sel = $urandom % 4;
      case (sel)
        0: begin code = 1; arg = {15'd0, 1'($urandom), 16'($urandom % 40)}; end
        1: begin code = 2; arg = $urandom % 6; end
        2: begin code = 4 + ($urandom % 20); arg = $urandom; end
        default: begin code = 1; arg = $urandom; end
      endcase
      run_cmd(code, arg, $urandom, $urandom, $urandom, 1'($urandom));
    end

    // R8 link rendezvous
    chk(!local_bound, "R8 not bound before command", local_bound, 0);
    run_cmd(3, 0, 0, 0, 0, 1'b0);
    chk(local_bound, "R8 bound after command", local_bound, 1);
    begin
      int pulses = 0;
      for (int i = 0; i < 10; i++) begin if (link_up) pulses++; tick; end
      chk(pulses == 0, "R8 no pulse with peer unbound", pulses, 0);
      peer_bound = 1'b1;
      for (int i = 0; i < 10; i++) begin if (link_up) pulses++; tick; end
      chk(pulses == 1, "R8 single pulse", pulses, 1);
      run_cmd(3, 0, 0, 0, 0, 1'b0);
      pulses = 0;
      for (int i = 0; i < 10; i++) begin if (link_up) pulses++; tick; end
      chk(pulses == 0, "R8 no second pulse", pulses, 0);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule